// File: doc/BRIEF.md
# Prioritised Request Sequencer for a Shared-Memory FIFO Pair

This block is the control engine behind two FIFOs, one carrying outbound (transmit) data and one carrying inbound (receive) data, that live side by side in one single-port RAM. Requesters raise one-cycle pulses asking to flush, push or pop either FIFO. Every pulse is remembered in its own pending flag. The sequencer then takes the pending work one item at a time, in a fixed order of importance.

The controller has no program counter. A small table indexed by the present state gives the following state, plus a flag saying whether that step must consult the arbiter. A wildcard-matching priority picker chooses among the pending flags. Each service takes two steps: the memory access, then the acknowledge. After that the machine spends one cycle in idle and arbitrates again.

The block drives the RAM's address, enable, write-enable and write data. It keeps the head, tail and occupancy of both FIFOs, reports which request was served, flags pushes into a full FIFO and pops from an empty one, and holds the most recent popped word on its output.

Top module: `fifo_req_seq`

## Requirements
- R1: A one-cycle pulse on any bit of `req_i` leaves that request pending until the sequencer acknowledges it. Further pulses of the same bit while it is pending merge into it. The request is acknowledged exactly once, and the write data captured by the latest pulse is the data stored.
- R2: Bit positions of `req_i` are 0 flush transmit, 1 flush receive, 2 push transmit, 3 push receive, 4 pop transmit, 5 pop receive. A lower bit always wins over a higher bit. `ack_id_o` reports the served request's bit position as a 3-bit number.
- R3: Two cycles after the idle cycle that picks a request, `ack_o` is high for exactly one cycle. The sequencer then spends at least one cycle in idle before its next acknowledge.
- R4: The transmit FIFO occupies RAM addresses with the top address bit 0 and the receive FIFO those with it 1. The low address bits are the FIFO's own slot index. Each service makes at most one RAM access.
- R5: Each FIFO returns words in the order they were pushed, wrapping around its 2^AW slots. The count outputs give occupancy from 0 to 2^AW.
- R6: A flush sets that FIFO's count to zero, rewinds both of its indices, and discards any pending push or pop for the same FIFO that was pending at the flush acknowledge.
- R7: A push into a full FIFO or a pop from an empty FIFO is acknowledged with `err_o` high for that single cycle. The FIFO's count and contents are left unchanged.
- R8: `rd_data_o` shows the popped word from the acknowledge cycle of a successful pop and holds it through every later cycle until the next successful pop acknowledge, including failed pops.
- R9: Synchronous reset empties both FIFOs, drops all pending requests, clears `rd_data_o` and returns the sequencer to idle with no acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 6 | Request pulses, one bit per request type |
| tx_wdata_i | input | DW | Data for a transmit push, captured with its pulse |
| rx_wdata_i | input | DW | Data for a receive push, captured with its pulse |
| ack_o | output | 1 | Service acknowledge |
| ack_id_o | output | 3 | Bit position of the request being acknowledged |
| err_o | output | 1 | Full-push or empty-pop indication, valid with ack_o |
| rd_data_o | output | DW | Latest popped word |
| tx_count_o | output | AW+1 | Transmit FIFO occupancy |
| rx_count_o | output | AW+1 | Receive FIFO occupancy |
| mem_en_o | output | 1 | RAM access enable |
| mem_we_o | output | 1 | RAM write enable |
| mem_addr_o | output | AW+1 | RAM address |
| mem_wdata_o | output | DW | RAM write data |
| mem_rdata_i | input | DW | RAM read data, one cycle after the enabled read |

## Verification
The hardest case to reach is a flush that lands on top of pending push and pop requests for the same FIFO, because the arbiter must choose the flush first and the discard must happen before the other two are ever picked. The stimulus raises flush, push and pop for the receive FIFO in one cycle. It then checks for a single acknowledge, an empty receive FIFO and a quiet `ack_o` over the following cycles. Merged pulses and a reset arriving mid-service are brought about the same way, with pulses placed a set number of cycles apart.

// File: rtl/fifo_arb_pkg.sv
package fifo_arb_pkg;

    localparam int NREQ = 6;

    localparam logic [2:0] RQ_RST_TX = 3'd0;
    localparam logic [2:0] RQ_RST_RX = 3'd1;
    localparam logic [2:0] RQ_WR_TX  = 3'd2;
    localparam logic [2:0] RQ_WR_RX  = 3'd3;
    localparam logic [2:0] RQ_RD_TX  = 3'd4;
    localparam logic [2:0] RQ_RD_RX  = 3'd5;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_ACK   = 2'd2
    } st_e;

    // One word of the state table
    typedef struct packed {
        st_e  nxt;      // following state
        logic branch;   // consult the arbiter; stay idle on no hit
        logic access;   // memory/pointer step
        logic ack;      // acknowledge step
    } rom_w_t;

    function automatic rom_w_t rom_lookup(input st_e s);
        rom_w_t w;
        case (s)
            ST_IDLE:  w = '{nxt: ST_ISSUE, branch: 1'b1, access: 1'b0, ack: 1'b0};
            ST_ISSUE: w = '{nxt: ST_ACK,   branch: 1'b0, access: 1'b1, ack: 1'b0};
            ST_ACK:   w = '{nxt: ST_IDLE,  branch: 1'b0, access: 1'b0, ack: 1'b1};
            default:  w = '{nxt: ST_IDLE,  branch: 1'b0, access: 1'b0, ack: 1'b0};
        endcase
        return w;
    endfunction

endpackage

// File: rtl/arb_pending.sv
module arb_pending #(
    parameter int N = 6
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] pend_o
);
    logic [N-1:0] pend_d, pend_q;

    // a fresh pulse wins over a clear in the same cycle
    always_comb begin
        pend_d = (pend_q & ~clr_i) | set_i;
    end

    always_ff @(posedge clk) begin
        if (rst) pend_q <= '0;
        else     pend_q <= pend_d;
    end

    assign pend_o = pend_q;

    for (genvar i = 0; i < N; i++) begin : g_hold
        AST_PEND_HOLD: assert property (@(posedge clk) disable iff (rst)
            (pend_q[i] && !clr_i[i]) |=> pend_q[i]); // R1
    end
endmodule

// File: rtl/arb_prio_enc.sv
module arb_prio_enc (
    input  logic [5:0] req_i,
    output logic       hit_o,
    output logic [2:0] idx_o
);
    always_comb begin
        hit_o = 1'b1;
        idx_o = 3'd0;
        casez (req_i)
            6'b?????1: idx_o = 3'd0;
            6'b????10: idx_o = 3'd1;
            6'b???100: idx_o = 3'd2;
            6'b??1000: idx_o = 3'd3;
            6'b?10000: idx_o = 3'd4;
            6'b100000: idx_o = 3'd5;
            default: begin
                hit_o = 1'b0;
                idx_o = 3'd0;
            end
        endcase
    end

    logic [5:0] below;
    always_comb begin
        below = (6'd1 << idx_o) - 6'd1;
        if (!$isunknown(req_i) && (|req_i)) begin
            AST_LOWEST_WINS: assert (hit_o && req_i[idx_o] && ((req_i & below) == 6'd0)); // R2
        end
    end
endmodule

// File: rtl/arb_fifo_ptrs.sv
module arb_fifo_ptrs #(
    parameter int AW = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr_i,
    input  logic          push_i,
    input  logic          pop_i,
    output logic [AW-1:0] wptr_o,
    output logic [AW-1:0] rptr_o,
    output logic [AW:0]   count_o,
    output logic          full_o,
    output logic          empty_o
);
    localparam int          DEPTH   = 1 << AW;
    localparam logic [AW:0] DEPTH_C = DEPTH[AW:0];

    typedef struct packed {
        logic [AW-1:0] wptr;
        logic [AW-1:0] rptr;
        logic [AW:0]   cnt;
    } ptr_t;

    ptr_t ptr_d, ptr_q;

    always_comb begin
        ptr_d = ptr_q;
        if (clr_i) begin
            ptr_d = '0;
        end else begin
            if (push_i) ptr_d.wptr = ptr_q.wptr + 1'b1;
            if (pop_i)  ptr_d.rptr = ptr_q.rptr + 1'b1;
            if (push_i && !pop_i) ptr_d.cnt = ptr_q.cnt + 1'b1;
            if (pop_i && !push_i) ptr_d.cnt = ptr_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) ptr_q <= '0;
        else     ptr_q <= ptr_d;
    end

    assign wptr_o  = ptr_q.wptr;
    assign rptr_o  = ptr_q.rptr;
    assign count_o = ptr_q.cnt;
    assign full_o  = (ptr_q.cnt == DEPTH_C);
    assign empty_o = (ptr_q.cnt == '0);

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        ptr_q.cnt <= DEPTH_C); // R5
    AST_CLR_EMPTIES: assert property (@(posedge clk) disable iff (rst)
        clr_i |=> (count_o == '0)); // R6
endmodule

// File: rtl/fifo_req_seq.sv
module fifo_req_seq
    import fifo_arb_pkg::*;
#(
    parameter int DW = 8,
    parameter int AW = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [5:0]    req_i,
    input  logic [DW-1:0] tx_wdata_i,
    input  logic [DW-1:0] rx_wdata_i,
    output logic          ack_o,
    output logic [2:0]    ack_id_o,
    output logic          err_o,
    output logic [DW-1:0] rd_data_o,
    output logic [AW:0]   tx_count_o,
    output logic [AW:0]   rx_count_o,
    output logic          mem_en_o,
    output logic          mem_we_o,
    output logic [AW:0]   mem_addr_o,
    output logic [DW-1:0] mem_wdata_o,
    input  logic [DW-1:0] mem_rdata_i
);
    localparam int NF = 2;

    typedef struct packed {
        st_e           st;
        logic [2:0]    sel;
        logic          err;
        logic          rd_ok;
        logic [DW-1:0] rd_data;
        logic [DW-1:0] tx_wd;
        logic [DW-1:0] rx_wd;
    } seq_t;

    seq_t r_d, r_q;

    logic [NREQ-1:0]        pend, clr_pend;
    logic                   hit;
    logic [2:0]             grant;
    logic [NF-1:0]          f_clr, f_push, f_pop, f_full, f_empty;
    logic [NF-1:0][AW-1:0]  f_wptr, f_rptr;
    logic [NF-1:0][AW:0]    f_cnt;

    rom_w_t     w;
    logic       fsel;
    logic [1:0] kind;
    logic       is_rst, is_wr, is_rd;

    arb_pending #(.N(NREQ)) u_pend (
        .clk(clk), .rst(rst), .set_i(req_i), .clr_i(clr_pend), .pend_o(pend)
    );

    arb_prio_enc u_enc (
        .req_i(pend), .hit_o(hit), .idx_o(grant)
    );

    for (genvar g = 0; g < NF; g++) begin : g_fifo
        arb_fifo_ptrs #(.AW(AW)) u_ptrs (
            .clk(clk), .rst(rst),
            .clr_i(f_clr[g]), .push_i(f_push[g]), .pop_i(f_pop[g]),
            .wptr_o(f_wptr[g]), .rptr_o(f_rptr[g]), .count_o(f_cnt[g]),
            .full_o(f_full[g]), .empty_o(f_empty[g])
        );
    end

    always_comb begin
        r_d    = r_q;
        w      = rom_lookup(r_q.st);
        fsel   = r_q.sel[0];          // even codes: transmit, odd: receive
        kind   = r_q.sel[2:1];        // 0 flush, 1 push, 2 pop
        is_rst = (kind == 2'd0);
        is_wr  = (kind == 2'd1);
        is_rd  = (kind == 2'd2);

        f_clr    = '0;
        f_push   = '0;
        f_pop    = '0;
        clr_pend = '0;

        // next state: table field, gated by the arbiter on branch steps
        r_d.st = (w.branch && !hit) ? ST_IDLE : w.nxt;
        if (w.branch && hit) r_d.sel = grant;

        if (req_i[RQ_WR_TX]) r_d.tx_wd = tx_wdata_i;
        if (req_i[RQ_WR_RX]) r_d.rx_wd = rx_wdata_i;

        if (w.access) begin
            f_clr[fsel]  = is_rst;
            f_push[fsel] = is_wr && !f_full[fsel];
            f_pop[fsel]  = is_rd && !f_empty[fsel];
            r_d.err      = (is_wr && f_full[fsel]) || (is_rd && f_empty[fsel]);
            r_d.rd_ok    = is_rd && !f_empty[fsel];
        end

        if (w.ack) begin
            clr_pend[r_q.sel] = 1'b1;
            if (is_rst) begin
                clr_pend[RQ_WR_TX + {2'b00, fsel}] = 1'b1;
                clr_pend[RQ_RD_TX + {2'b00, fsel}] = 1'b1;
            end
            if (r_q.rd_ok) r_d.rd_data = mem_rdata_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) r_q <= '0;
        else     r_q <= r_d;
    end

    assign ack_o       = w.ack;
    assign ack_id_o    = r_q.sel;
    assign err_o       = w.ack && r_q.err;
    assign rd_data_o   = (w.ack && r_q.rd_ok) ? mem_rdata_i : r_q.rd_data;
    assign tx_count_o  = f_cnt[0];
    assign rx_count_o  = f_cnt[1];
    assign mem_en_o    = (|f_push) || (|f_pop);
    assign mem_we_o    = |f_push;
    assign mem_addr_o  = {fsel, (is_wr ? f_wptr[fsel] : f_rptr[fsel])};
    assign mem_wdata_o = fsel ? r_q.rx_wd : r_q.tx_wd;

    AST_ACK_AFTER_ISSUE: assert property (@(posedge clk) disable iff (rst)
        ack_o |-> ($past(r_q.st) == ST_ISSUE)); // R3
    AST_ERR_SINGLE: assert property (@(posedge clk) disable iff (rst)
        err_o |=> !err_o); // R7
    AST_ERR_NO_MOVE: assert property (@(posedge clk) disable iff (rst)
        (ack_o && err_o) |-> (tx_count_o == $past(tx_count_o) &&
                              rx_count_o == $past(rx_count_o))); // R7
    AST_RD_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(ack_o && !err_o && ack_id_o[2]) |=> $stable(r_q.rd_data)); // R8
endmodule

// File: tb/fifo_req_seq_bench.sv
`timescale 1ns/1ps
module fifo_req_seq_bench;
    localparam int DW = 8;
    localparam int AW = 2;

    logic          clk = 1'b0;
    logic          rst;
    logic [5:0]    req;
    logic [DW-1:0] tx_wd, rx_wd;
    logic          ack, err, mem_en, mem_we;
    logic [2:0]    ack_id;
    logic [DW-1:0] rd_data, mem_wdata, mem_rdata;
    logic [AW:0]   tx_cnt, rx_cnt, mem_addr;

    logic [DW-1:0] ram [0:(1<<(AW+1))-1];

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    fifo_req_seq #(.DW(DW), .AW(AW)) u_fifo_req_seq (
        .clk(clk), .rst(rst), .req_i(req),
        .tx_wdata_i(tx_wd), .rx_wdata_i(rx_wd),
        .ack_o(ack), .ack_id_o(ack_id), .err_o(err), .rd_data_o(rd_data),
        .tx_count_o(tx_cnt), .rx_count_o(rx_cnt),
        .mem_en_o(mem_en), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
        .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata)
    );

    // single-port synchronous RAM model
    always @(posedge clk) begin
        if (mem_en) begin
            if (mem_we) ram[mem_addr] <= mem_wdata;
            else        mem_rdata     <= ram[mem_addr];
        end
    end

    typedef struct packed {
        logic [5:0] mask;
        logic [7:0] data;
        logic [2:0] id;
        logic       err;
        logic [7:0] rd;
        logic [2:0] tx;
        logic [2:0] rx;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{6'b000100, 8'h11, 3'd2, 1'b0, 8'h00, 3'd1, 3'd0},
        '{6'b000100, 8'h22, 3'd2, 1'b0, 8'h00, 3'd2, 3'd0},
        '{6'b001000, 8'hA5, 3'd3, 1'b0, 8'h00, 3'd2, 3'd1},
        '{6'b010000, 8'h00, 3'd4, 1'b0, 8'h11, 3'd1, 3'd1},
        '{6'b100000, 8'h00, 3'd5, 1'b0, 8'hA5, 3'd1, 3'd0},
        '{6'b100000, 8'h00, 3'd5, 1'b1, 8'hA5, 3'd1, 3'd0},
        '{6'b010000, 8'h00, 3'd4, 1'b0, 8'h22, 3'd0, 3'd0},
        '{6'b000100, 8'h33, 3'd2, 1'b0, 8'h22, 3'd1, 3'd0}
    };

    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic pulse(input logic [5:0] m, input logic [7:0] d);
        @(negedge clk);
        req = m; tx_wd = d; rx_wd = d;
        @(negedge clk);
        req = '0;
    endtask

    task automatic wait_ack(input string tag);
        bit got = 1'b0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (ack) begin got = 1'b1; break; end
        end
        check({tag, " ack seen"}, int'(got), 1);
    endtask

    task automatic quiet(input string tag, input int n);
        bit seen = 1'b0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (ack) seen = 1'b1;
        end
        check({tag, " no ack"}, int'(seen), 0);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; req = '0; tx_wd = '0; rx_wd = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R9 reset state
        check("R9 ack after reset", int'(ack), 0);
        check("R9 tx count", int'(tx_cnt), 0);
        check("R9 rx count", int'(rx_cnt), 0);
        check("R9 rd data", int'(rd_data), 0);

        // table walk: R2 ids, R4/R5 ordering, R7 empty pop, R8 hold
        for (int v = 0; v < NV; v++) begin
            pulse(VECS[v].mask, VECS[v].data);
            // R3 timing: ack exactly two cycles after the picking idle cycle
            @(negedge clk); // ISSUE
            check("R3 no early ack", int'(ack), 0);
            @(negedge clk); // ACK
            check("R3 ack on time", int'(ack), 1);
            check("R2 ack id", int'(ack_id), int'(VECS[v].id));
            check("R7 err flag", int'(err), int'(VECS[v].err));
            check("R8 read data", int'(rd_data), int'(VECS[v].rd));
            check("R5 tx count", int'(tx_cnt), int'(VECS[v].tx));
            check("R5 rx count", int'(rx_cnt), int'(VECS[v].rx));
            @(negedge clk);
            check("R3 ack one cycle", int'(ack), 0);
            check("R7 err one cycle", int'(err), 0);
        end

        // R2 priority with simultaneous requests
        pulse(6'b011100, 8'h44);
        wait_ack("R2 first");
        check("R2 first id", int'(ack_id), 2);
        wait_ack("R2 second");
        check("R2 second id", int'(ack_id), 3);
        wait_ack("R2 third");
        check("R2 third id", int'(ack_id), 4);
        check("R5 pop order", int'(rd_data), 8'h33);
        check("R5 tx after", int'(tx_cnt), 1);
        check("R4 rx slot", int'(rx_cnt), 1);

        // R6 flush discards same-FIFO push and pop
        pulse(6'b101010, 8'h99);
        wait_ack("R6 flush");
        check("R6 flush id", int'(ack_id), 1);
        check("R6 rx empty", int'(rx_cnt), 0);
        quiet("R6 cancelled", 10);
        check("R6 rx still empty", int'(rx_cnt), 0);

        // R7 push into full, R5 wrap order
        for (int k = 0; k < 3; k++) begin
            pulse(6'b000100, 8'h60 + 8'(k));
            wait_ack("R5 fill");
        end
        check("R5 tx full", int'(tx_cnt), 4);
        pulse(6'b000100, 8'hEE);
        wait_ack("R7 full");
        check("R7 full err", int'(err), 1);
        check("R7 full count", int'(tx_cnt), 4);
        pulse(6'b010000, 8'h00);
        wait_ack("R5 wrap pop");
        check("R5 wrap data", int'(rd_data), 8'h44);
        pulse(6'b010000, 8'h00);
        wait_ack("R5 wrap pop2");
        check("R5 wrap data2", int'(rd_data), 8'h60);

        // R6 flush transmit, then R7/R8 empty pop holds data
        pulse(6'b000001, 8'h00);
        wait_ack("R6 tx flush");
        check("R6 tx flush id", int'(ack_id), 0);
        check("R6 tx empty", int'(tx_cnt), 0);
        pulse(6'b010000, 8'h00);
        wait_ack("R7 empty pop");
        check("R7 empty err", int'(err), 1);
        check("R8 held data", int'(rd_data), 8'h60);
        @(negedge clk);
        check("R8 held after", int'(rd_data), 8'h60);

        // R9 reset in the middle of a service
        pulse(6'b001000, 8'h5A);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        check("R9 rx cleared", int'(rx_cnt), 0);
        check("R9 rd cleared", int'(rd_data), 0);
        quiet("R9 dropped", 8);

        // R1 merged pulses: one ack, latest data
        @(negedge clk);
        req = 6'b001000; rx_wd = 8'h70;
        @(negedge clk);
        req = 6'b001000; rx_wd = 8'h71;
        @(negedge clk);
        req = '0;
        wait_ack("R1 merged");
        check("R1 merged id", int'(ack_id), 3);
        check("R1 one entry", int'(rx_cnt), 1);
        quiet("R1 single ack", 8);
        pulse(6'b100000, 8'h00);
        wait_ack("R1 pop");
        check("R1 latest data", int'(rd_data), 8'h71);
        check("R1 rx empty", int'(rx_cnt), 0);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule